// File: doc/BRIEF.md
# Receive status ring writer

This block turns each finished receive frame into a two-word completion record in a circular status ring held in system memory. The MAC side offers a frame summary: the buffer index it filled, the byte length, five error flags, a CRC-kept flag, an address-match class and a hash bucket. The block accepts the summary and builds the record. It writes the record through a one-word-per-cycle memory write port at the current ring slot, moves to the next slot, and raises a receive interrupt.

Software controls the flow by returning credits. It writes a count of freed receive buffers and a count of consumed status slots. The block holds back the next frame while either pool is empty, so a record that software has not yet read is never overwritten. At start-up software returns the full ring depth for both pools. Frames longer than the programmed maximum are still recorded, but they are never marked as good.

Top module: `rx_status_ring_writer`

## Requirements
- R1: After reset, mem_we is low, both credit counts are 0, fr_ready is low, and rx_int_pending and irq are low.
- R2: A credit-return strobe adds its count to the matching pool. Each pool saturates at ENTRIES. Each accepted frame takes one credit from each pool.
- R3: fr_ready is high only when the writer is idle and both pools hold at least one credit. While fr_ready is low, a frame offered on fr_valid is not written to memory.
- R4: A frame accepted on a clock edge produces word 0 on the port in the next cycle, at the current slot address. Word 1 follows in the cycle after that, at the slot address plus 4. Each write is one cycle with mem_we high.
- R5: Word 0 has the following layout. Bit 31 is the processed flag and is always 1. Bit 29 is end-of-frame and bit 28 is end-of-buffer, both always 1. Bits 23:22 carry fr_addr_match. Bit 15 carries fr_crc_incl. Bits 13:8 carry fr_hash. Bits 27:24, bit 14 and bits 7:0 are 0.
- R6: fr_err maps into word 0 as follows: fr_err[4] (overrun) goes to bit 20, fr_err[3] (framing) to bit 19, fr_err[2] (runt) to bit 18, fr_err[1] (excess data) to bit 17, and fr_err[0] (CRC) to bit 16. Bit 21 is the OR of all error conditions. Bit 30 (good frame) is its inverse.
- R7: A frame with fr_len greater than max_len sets bits 17 and 21 and clears bit 30. A length equal to max_len counts as good.
- R8: Word 1 has bit 31 set to 1, bits 30:16 set to fr_buf_idx and bits 15:0 set to fr_len.
- R9: The slot address starts at ring_base and advances by 8 bytes per record. After the last of ENTRIES slots it wraps back to ring_base. A ring_init pulse returns it to ring_base.
- R10: rx_int_pending rises in the cycle after word 1 is written and stays high until rx_int_clr. irq equals rx_int_pending AND rx_int_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_init | input | 1 | Return slot pointer to ring base |
| ring_base | input | AW | Byte address of slot 0 |
| max_len | input | 16 | Largest length reported as good |
| desc_ret_we | input | 1 | Buffer credit return strobe |
| desc_ret_cnt | input | CW | Buffer credits returned |
| sts_ret_we | input | 1 | Status slot credit return strobe |
| sts_ret_cnt | input | CW | Status slots returned |
| fr_valid | input | 1 | Frame summary offered |
| fr_ready | output | 1 | Frame summary accepted this cycle |
| fr_buf_idx | input | 15 | Buffer index consumed by the frame |
| fr_len | input | 16 | Frame length in bytes |
| fr_err | input | 5 | Overrun, framing, runt, excess data, CRC |
| fr_crc_incl | input | 1 | CRC kept in buffer |
| fr_addr_match | input | 2 | Address-match class |
| fr_hash | input | 6 | Hash bucket |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| desc_credits | output | CW | Buffer credits held |
| sts_credits | output | CW | Status slot credits held |
| rx_int_en | input | 1 | Receive interrupt enable |
| rx_int_clr | input | 1 | Clear pending receive interrupt |
| rx_int_pending | output | 1 | Receive interrupt status |
| irq | output | 1 | Enabled receive interrupt |

## Verification
The hardest case to reach is a frame waiting on fr_valid while one credit pool is empty and the other is not. Reaching it takes a full ring of records with no returns, then a return to only one pool. The bench reaches it by running a four-slot configuration past its depth. It then holds fr_valid high, watches the write port stay silent, and returns buffer credits before status credits. A sweep of all 32 error-flag patterns at lengths one below, equal to and one above the maximum covers the flag mapping and the length limit.

// File: rtl/rx_status_ring_writer.sv
module rx_status_ring_writer #(
  parameter int ENTRIES = 64,
  parameter int AW = 32,
  localparam int CW = $clog2(ENTRIES) + 1,
  localparam int RING_BYTES = ENTRIES * 8,
  localparam int OW = $clog2(RING_BYTES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ring_init,
  input  logic [AW-1:0] ring_base,
  input  logic [15:0]   max_len,
  input  logic          desc_ret_we,
  input  logic [CW-1:0] desc_ret_cnt,
  input  logic          sts_ret_we,
  input  logic [CW-1:0] sts_ret_cnt,
  input  logic          fr_valid,
  output logic          fr_ready,
  input  logic [14:0]   fr_buf_idx,
  input  logic [15:0]   fr_len,
  input  logic [4:0]    fr_err,
  input  logic          fr_crc_incl,
  input  logic [1:0]    fr_addr_match,
  input  logic [5:0]    fr_hash,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [CW-1:0] desc_credits,
  output logic [CW-1:0] sts_credits,
  input  logic          rx_int_en,
  input  logic          rx_int_clr,
  output logic          rx_int_pending,
  output logic          irq
);

  localparam logic [1:0] PH_IDLE = 2'd0, PH_W0 = 2'd1, PH_W1 = 2'd2;

  logic [1:0]    phase;
  logic [OW-1:0] slot_off;
  logic [31:0]   word0, word1;

  wire take    = fr_valid && fr_ready;
  wire too_long = fr_len > max_len;
  wire bad     = (|fr_err) || too_long;

  wire [CW:0] d_sum = {1'b0, desc_credits} + (desc_ret_we ? {1'b0, desc_ret_cnt} : '0) - {{CW{1'b0}}, take};
  wire [CW:0] s_sum = {1'b0, sts_credits} + (sts_ret_we ? {1'b0, sts_ret_cnt} : '0) - {{CW{1'b0}}, take};

  assign fr_ready  = (phase == PH_IDLE) && (desc_credits != '0) && (sts_credits != '0);
  assign mem_we    = (phase != PH_IDLE);
  assign mem_addr  = ring_base + AW'(slot_off) + ((phase == PH_W1) ? AW'(4) : AW'(0));
  assign mem_wdata = (phase == PH_W1) ? word1 : word0;
  assign irq       = rx_int_pending && rx_int_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase          <= PH_IDLE;
      slot_off       <= '0;
      word0          <= '0;
      word1          <= '0;
      desc_credits   <= '0;
      sts_credits    <= '0;
      rx_int_pending <= 1'b0;
    end else begin
      desc_credits <= (d_sum > ENTRIES) ? CW'(ENTRIES) : d_sum[CW-1:0];
      sts_credits  <= (s_sum > ENTRIES) ? CW'(ENTRIES) : s_sum[CW-1:0];

      case (phase)
        PH_IDLE: if (take) begin
          phase <= PH_W0;
          word0 <= {1'b1, !bad, 1'b1, 1'b1, 4'b0, fr_addr_match, bad,
                    fr_err[4:2], fr_err[1] | too_long, fr_err[0],
                    fr_crc_incl, 1'b0, fr_hash, 8'b0};
          word1 <= {1'b1, fr_buf_idx, fr_len};
        end
        PH_W0: phase <= PH_W1;
        default: begin
          phase    <= PH_IDLE;
          slot_off <= (slot_off == OW'(RING_BYTES - 8)) ? '0 : slot_off + OW'(8);
        end
      endcase

      if (ring_init) slot_off <= '0;

      if (phase == PH_W1)  rx_int_pending <= 1'b1;
      else if (rx_int_clr) rx_int_pending <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_status_ring_writer_chk.sv
module rx_status_ring_writer_chk #(
  parameter int ENTRIES = 64,
  parameter int AW = 32,
  localparam int CW = $clog2(ENTRIES) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ring_init,
  input logic [AW-1:0] ring_base,
  input logic [15:0]   max_len,
  input logic          fr_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [CW-1:0] desc_credits,
  input logic [CW-1:0] sts_credits,
  input logic          rx_int_pending
);

  AST_READY_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    fr_ready |-> (desc_credits != '0 && sts_credits != '0)) else $error("ready without credit"); // R3

  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_credits <= ENTRIES) && (sts_credits <= ENTRIES)) else $error("credit overflow"); // R2

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !fr_ready) else $error("ready while writing"); // R3

  AST_WORD1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |=> (mem_we && mem_addr == $past(mem_addr) + AW'(4))) else $error("word 1 missing"); // R4

  AST_PROCESSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[31]) else $error("processed flag clear"); // R5

  AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n || ring_init)
    mem_we |-> (mem_addr - ring_base) < AW'(ENTRIES * 8)) else $error("address outside ring"); // R9

  AST_GOOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we) && mem_wdata[30]) |=> (mem_wdata[15:0] <= max_len)) else $error("long frame good"); // R7

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_int_pending) |-> $past(mem_we)) else $error("interrupt without record"); // R10

endmodule

bind rx_status_ring_writer rx_status_ring_writer_chk #(.ENTRIES(ENTRIES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_init(ring_init), .ring_base(ring_base),
  .max_len(max_len), .fr_ready(fr_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .desc_credits(desc_credits), .sts_credits(sts_credits),
  .rx_int_pending(rx_int_pending)
);

// File: tb/test_rx_status_ring_writer.sv
`timescale 1ns/1ps
module test_rx_status_ring_writer;
  localparam int ENTRIES = 4;
  localparam int AW = 32;
  localparam int CW = $clog2(ENTRIES) + 1;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [15:0] MAXL = 16'd100;

  logic clk = 0, rst_n = 0, ring_init = 0;
  logic [AW-1:0] ring_base = BASE;
  logic [15:0] max_len = MAXL;
  logic desc_ret_we = 0, sts_ret_we = 0;
  logic [CW-1:0] desc_ret_cnt = 0, sts_ret_cnt = 0;
  logic fr_valid = 0, fr_ready;
  logic [14:0] fr_buf_idx = 0;
  logic [15:0] fr_len = 0;
  logic [4:0] fr_err = 0;
  logic fr_crc_incl = 0;
  logic [1:0] fr_addr_match = 0;
  logic [5:0] fr_hash = 0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [CW-1:0] desc_credits, sts_credits;
  logic rx_int_en = 1, rx_int_clr = 0, rx_int_pending, irq;

  int checks = 0, fails = 0, slot = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_status_ring_writer #(.ENTRIES(ENTRIES), .AW(AW)) i_rx_status_ring_writer (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic give(bit d, bit s, int n);
    desc_ret_we = d; sts_ret_we = s;
    desc_ret_cnt = CW'(n); sts_ret_cnt = CW'(n);
    @(negedge clk);
    desc_ret_we = 0; sts_ret_we = 0;
    @(negedge clk);
  endtask

  task automatic frame(logic [14:0] idx, logic [15:0] len, logic [4:0] err,
                       logic crci, logic [1:0] am, logic [5:0] hash);
    logic bad;
    logic [31:0] w0, w1, a;
    bad = (|err) || (len > MAXL);
    w0 = {1'b1, !bad, 2'b11, 4'b0, am, bad, err[4:2], err[1] | (len > MAXL), err[0],
          crci, 1'b0, hash, 8'b0};
    w1 = {1'b1, idx, len};
    a = BASE + 32'(8 * (slot % ENTRIES));
    chk("R3 ready before frame", {31'b0, fr_ready}, 1);
    fr_valid = 1; fr_buf_idx = idx; fr_len = len; fr_err = err;
    fr_crc_incl = crci; fr_addr_match = am; fr_hash = hash;
    @(negedge clk);
    fr_valid = 0;
    chk("R4 word0 strobe", {31'b0, mem_we}, 1);
    chk("R9 word0 address", mem_addr, a);
    chk("R5 R6 R7 word0", mem_wdata, w0);
    @(negedge clk);
    chk("R4 word1 strobe", {31'b0, mem_we}, 1);
    chk("R4 word1 address", mem_addr, a + 4);
    chk("R8 word1", mem_wdata, w1);
    @(negedge clk);
    chk("R4 single pair", {31'b0, mem_we}, 0);
    chk("R10 pending set", {31'b0, rx_int_pending}, 1);
    chk("R10 irq gated", {31'b0, irq}, {31'b0, rx_int_en});
    rx_int_clr = 1;
    @(negedge clk);
    rx_int_clr = 0;
    chk("R10 pending cleared", {31'b0, rx_int_pending}, 0);
    slot++;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_tb();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mem_we", {31'b0, mem_we}, 0);
    chk("R1 desc credits", 32'(desc_credits), 0);
    chk("R1 sts credits", 32'(sts_credits), 0);
    chk("R1 ready", {31'b0, fr_ready}, 0);
    chk("R1 irq", {30'b0, rx_int_pending, irq}, 0);
    rst_n = 1;
    ring_init = 1; @(negedge clk); ring_init = 0;

    give(1, 1, ENTRIES);
    chk("R2 initial desc", 32'(desc_credits), ENTRIES);
    chk("R2 initial sts", 32'(sts_credits), ENTRIES);
    give(1, 1, 7);
    chk("R2 saturate desc", 32'(desc_credits), ENTRIES);
    chk("R2 saturate sts", 32'(sts_credits), ENTRIES);

    for (int f = 0; f < 96; f++) begin
      rx_int_en = f[3];
      frame(15'((f * 37 + 5) & 16'h7fff), MAXL - 16'd1 + 16'(f / 32), 5'(f),
            f[2], 2'(f), 6'(f * 3));
      chk("R2 take one", 32'(sts_credits), ENTRIES - 1);
      give(1, 1, 1);
    end
    rx_int_en = 1;

    for (int f = 0; f < ENTRIES; f++)
      frame(15'h7fff, 16'hffff, 5'b0, 1'b0, 2'b11, 6'h3f);
    chk("R2 desc drained", 32'(desc_credits), 0);
    chk("R3 ready low when empty", {31'b0, fr_ready}, 0);
    fr_valid = 1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R3 held frame not written", {31'b0, mem_we}, 0);
    end
    fr_valid = 0;
    give(1, 0, 1);
    chk("R3 one pool still empty", {31'b0, fr_ready}, 0);
    give(0, 1, 2);
    chk("R2 status return", 32'(sts_credits), 2);
    chk("R3 ready restored", {31'b0, fr_ready}, 1);

    frame(15'h0001, MAXL, 5'b0, 1'b1, 2'b01, 6'h15);
    give(1, 0, 1);
    ring_init = 1; @(negedge clk); ring_init = 0;
    slot = 0;
    frame(15'h0002, 16'd60, 5'b10001, 1'b0, 2'b10, 6'h2a);
    chk("R9 next slot after init", 32'(slot), 1);

    finish_tb();
  end
endmodule